// File: doc/BRIEF.md
# Clock Register File Index/Data Access Port

This block gives a processor two byte-wide ports onto the 128-byte register file of a real-time clock. A write to the index port picks a register. Later reads and writes on the data port then reach that register. Most bytes are plain storage. The four control bytes at indices 10 to 13 follow their own write rules. The time-keeping bytes at indices 0 to 9 can also be loaded by the clock's counting logic.

The block drives the decoded control fields to the neighbouring clock blocks. These fields are the rate select, the divider field, the three interrupt enables, the hold (set) mode, and the binary-data and 24-hour mode bits. It also raises a one-cycle request telling the counter to reload its running time from the time registers.

The counter and the periodic/alarm logic drive a few inputs back into the block. These set and clear the update-in-progress flag and post the interrupt flags that build the status byte. Bit 7 of the status byte drives the interrupt output.

A small state machine tracks the hold mode. Its states are:
- `S_RUN`: normal running.
- `S_HOLD`: control bit 7 is set.
- `S_RELOAD`: a single cycle during which `reload_req` is high.

Its transitions are:
- `S_RUN`→`S_HOLD` on a control write with bit 7 set.
- `S_RUN`→`S_RELOAD` on a time-register write.
- `S_HOLD`→`S_RELOAD` on a control write with bit 7 clear.
- `S_RELOAD`→`S_HOLD` on a control write with bit 7 set.
- `S_RELOAD`→`S_RELOAD` on another time-register write.
- `S_RELOAD`→`S_RUN` otherwise.

Top module: `rtc_regif`

## Requirements
- R1: A strobed write with `bus_sel`=0 loads the 8-bit index. A strobed read with `bus_sel`=0 returns the full 8-bit index. Data-port accesses use the index modulo 128, so index 0xA1 reaches byte 0x21.
- R2: A strobed data write stores `bus_wdata` at the indexed byte. A strobed data read loads `bus_rdata` with that byte at the strobe's clock edge. `bus_rdata` holds its value when no read is strobed.
- R3: After reset, the control bytes are: index 10 = 0x26, index 11 = 0x02, index 12 = 0x00, index 13 = 0x80. The decoded outputs are:
  - `rate_sel` = byte10[3:0], `div_sel` = byte10[6:4], `uip` = byte10[7].
  - `set_mode` = byte11[7], `pie` = byte11[6], `aie` = byte11[5], `uie` = byte11[4], `bin_mode` = byte11[2], `h24_mode` = byte11[1].
- R4: A data write to index 10 replaces bits 6..0 and leaves bit 7 (update in progress) unchanged.
- R5: A data write to index 11 with bit 7 set stores the value with bit 4 forced to 0. It also clears the update-in-progress bit.
- R6: `reload_req` is high for exactly the cycle after either of two events: a data write to indices 0..9 while `set_mode` is 0, or a write to index 11 that changes bit 7 from 1 to 0. A time-register write while `set_mode` is 1 raises no request.
- R7: A pulse on `upd_we` stores `upd_data` at `upd_idx` only when the index is 0, 2, 4, 6, 7, 8 or 9 and `set_mode` is 0. Otherwise the pulse changes nothing.
- R8: `uip_set` sets the update-in-progress bit unless `set_mode` is 1. `uip_clr` clears the bit.
- R9: Each bit of `flag_set` sets a status bit: bit 2 sets byte12[6], bit 1 sets byte12[5], bit 0 sets byte12[4]. Any nonzero `flag_set` also sets byte12[7], and `irq` equals byte12[7].
- R10: A data read of index 12 returns the status byte and then clears it to 0, which drops `irq`.
- R11: Data writes to indices 12 and 13 change nothing. Index 13 always reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| upd_we | input | 1 | Time-byte load strobe from the counter |
| upd_idx | input | 7 | Index for the counter's load |
| upd_data | input | 8 | Data for the counter's load |
| uip_set | input | 1 | Set the update-in-progress bit |
| uip_clr | input | 1 | Clear the update-in-progress bit |
| flag_set | input | 3 | Post flags {periodic, alarm, update-ended} |
| rate_sel | output | 4 | Rate select field |
| div_sel | output | 3 | Divider field |
| pie | output | 1 | Periodic interrupt enable |
| aie | output | 1 | Alarm interrupt enable |
| uie | output | 1 | Update-ended interrupt enable |
| set_mode | output | 1 | Hold mode; counter must not copy time |
| bin_mode | output | 1 | 1 = binary data, 0 = BCD |
| h24_mode | output | 1 | 1 = 24-hour, 0 = 12-hour |
| uip | output | 1 | Update-in-progress bit |
| reload_req | output | 1 | One-cycle request to reload time |
| irq | output | 1 | Interrupt request |

## Verification
Every register in the block changes at the clock edge where its strobe or pulse is high. `bus_rdata` and the decoded fields are therefore due one edge after stimulus. The bench sets inputs on a falling edge, waits one rising edge, and samples at the next falling edge. `reload_req` is valid only in that one sampled cycle, and the bench samples it again one cycle later to confirm it has dropped. Status clearing and ignored writes are observed through a later data read or through the `irq` pin.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
    localparam int IDX_CTLA = 10;
    localparam int IDX_CTLB = 11;
    localparam int IDX_STAT = 12;
    localparam int IDX_VALID = 13;
    localparam int NUM_TIME = 10;

    localparam logic [7:0] CTLA_RST  = 8'h26;
    localparam logic [7:0] CTLB_RST  = 8'h02;
    localparam logic [7:0] STAT_RST  = 8'h00;
    localparam logic [7:0] VALID_VAL = 8'h80;

    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_HOLD   = 2'd1,
        S_RELOAD = 2'd2
    } hold_state_e;
endpackage

// File: rtl/rtc_regif_port.sv
module rtc_regif_port #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          we,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd_value,
    output logic [AW-1:0] cur_idx,
    output logic          dat_wr,
    output logic          dat_rd,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            rdata <= '0;
        end else if (stb) begin
            if (we && !sel) idx_q <= wdata;
            if (!we)        rdata <= sel ? rd_value : idx_q;
        end
    end

    assign cur_idx = idx_q[AW-1:0];
    assign dat_wr  = stb && we && sel;
    assign dat_rd  = stb && !we && sel;
endmodule

// File: rtl/rtc_regif_ram.sv
module rtc_regif_ram #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          upd_we,
    input  logic [AW-1:0] upd_idx,
    input  logic [DW-1:0] upd_data,
    input  logic          hold,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    import rtc_regif_pkg::*;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          upd_ok;

    always_comb begin
        unique case (int'(upd_idx))
            0, 2, 4, 6, 7, 8, 9: upd_ok = upd_we && !hold;
            default:             upd_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (upd_ok) mem[upd_idx] <= upd_data;
        if (wr_en)  mem[wr_idx]  <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rtc_regif_ctrl.sv
module rtc_regif_ctrl #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    input  logic          uip_set,
    input  logic          uip_clr,
    input  logic [2:0]    flag_set,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_b,
    output logic [DW-1:0] reg_c,
    output logic [DW-1:0] reg_d,
    output logic          reload_req
);
    import rtc_regif_pkg::*;

    hold_state_e state_q, state_d;
    logic        wr_a, wr_b, wr_time, rd_c, set_on, set_off;
    logic [DW-1:0] c_post;

    assign wr_a    = dat_wr && int'(idx) == IDX_CTLA;
    assign wr_b    = dat_wr && int'(idx) == IDX_CTLB;
    assign wr_time = dat_wr && int'(idx) < NUM_TIME && !reg_b[7];
    assign rd_c    = dat_rd && int'(idx) == IDX_STAT;
    assign set_on  = wr_b && wdata[7];
    assign set_off = wr_b && !wdata[7] && reg_b[7];

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN: begin
                if (set_on)       state_d = S_HOLD;
                else if (wr_time) state_d = S_RELOAD;
            end
            S_HOLD: begin
                if (set_off)      state_d = S_RELOAD;
            end
            S_RELOAD: begin
                if (set_on)       state_d = S_HOLD;
                else if (wr_time) state_d = S_RELOAD;
                else              state_d = S_RUN;
            end
            default:              state_d = S_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        reload_req = (state_q == S_RELOAD);
    end

    always_comb begin
        c_post = rd_c ? '0 : reg_c;
        if (|flag_set) c_post = c_post | {1'b1, flag_set, 4'b0000};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a <= CTLA_RST;
            reg_b <= CTLB_RST;
            reg_c <= STAT_RST;
        end else begin
            if (wr_a) reg_a[6:0] <= wdata[6:0];
            if (set_on)                      reg_a[7] <= 1'b0;
            else if (uip_set && !reg_b[7])   reg_a[7] <= 1'b1;
            else if (uip_clr)                reg_a[7] <= 1'b0;
            if (wr_b) reg_b <= set_on ? (wdata & 8'hEF) : wdata;
            reg_c <= c_post;
        end
    end

    assign reg_d = VALID_VAL;
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_stb,
    input  logic          bus_we,
    input  logic          bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          upd_we,
    input  logic [AW-1:0] upd_idx,
    input  logic [DW-1:0] upd_data,
    input  logic          uip_set,
    input  logic          uip_clr,
    input  logic [2:0]    flag_set,
    output logic [3:0]    rate_sel,
    output logic [2:0]    div_sel,
    output logic          pie,
    output logic          aie,
    output logic          uie,
    output logic          set_mode,
    output logic          bin_mode,
    output logic          h24_mode,
    output logic          uip,
    output logic          reload_req,
    output logic          irq
);
    import rtc_regif_pkg::*;

    logic [AW-1:0] cur_idx;
    logic          dat_wr, dat_rd;
    logic [DW-1:0] rd_value, ram_rd;
    logic [DW-1:0] reg_a, reg_b, reg_c, reg_d;

    rtc_regif_port #(.DW(DW), .AW(AW)) port_i (
        .clk(clk), .rst_n(rst_n), .stb(bus_stb), .we(bus_we), .sel(bus_sel),
        .wdata(bus_wdata), .rd_value(rd_value), .cur_idx(cur_idx),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .rdata(bus_rdata)
    );

    rtc_regif_ram #(.DW(DW), .AW(AW)) ram_i (
        .clk(clk), .wr_en(dat_wr), .wr_idx(cur_idx), .wr_data(bus_wdata),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_data(upd_data),
        .hold(reg_b[7]), .rd_idx(cur_idx), .rd_data(ram_rd)
    );

    rtc_regif_ctrl #(.DW(DW), .AW(AW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .idx(cur_idx), .wdata(bus_wdata), .uip_set(uip_set), .uip_clr(uip_clr),
        .flag_set(flag_set), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
        .reg_d(reg_d), .reload_req(reload_req)
    );

    always_comb begin
        unique case (int'(cur_idx))
            IDX_CTLA:  rd_value = reg_a;
            IDX_CTLB:  rd_value = reg_b;
            IDX_STAT:  rd_value = reg_c;
            IDX_VALID: rd_value = reg_d;
            default:   rd_value = ram_rd;
        endcase
    end

    assign rate_sel = reg_a[3:0];
    assign div_sel  = reg_a[6:4];
    assign uip      = reg_a[7];
    assign set_mode = reg_b[7];
    assign pie      = reg_b[6];
    assign aie      = reg_b[5];
    assign uie      = reg_b[4];
    assign bin_mode = reg_b[2];
    assign h24_mode = reg_b[1];
    assign irq      = reg_c[7];
endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dat_wr,
    input logic          dat_rd,
    input logic [AW-1:0] cur_idx,
    input logic [DW-1:0] bus_wdata,
    input logic          uip_set,
    input logic          uip_clr,
    input logic [2:0]    flag_set,
    input logic          uip,
    input logic          uie,
    input logic          set_mode,
    input logic          reload_req,
    input logic          irq
);
    import rtc_regif_pkg::*;

    p_uip_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && int'(cur_idx) == IDX_CTLA && !uip_set && !uip_clr) |=> (uip == $past(uip)));

    p_hold_no_uie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |-> !uie);

    p_hold_clears_uip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && int'(cur_idx) == IDX_CTLB && bus_wdata[7]) |=> !uip);

    p_exit_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(set_mode) |-> reload_req);

    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && $past(set_mode)) |-> !reload_req);

    p_flag_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> irq);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && int'(cur_idx) == IDX_STAT && flag_set == 3'b000) |=> !irq);
endmodule

bind rtc_regif rtc_regif_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .cur_idx(cur_idx), .bus_wdata(bus_wdata), .uip_set(uip_set),
    .uip_clr(uip_clr), .flag_set(flag_set), .uip(uip), .uie(uie),
    .set_mode(set_mode), .reload_req(reload_req), .irq(irq)
);

// File: tb/rtc_regif_tb_top.sv
module rtc_regif_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_stb = 1'b0, bus_we = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       upd_we = 1'b0;
    logic [6:0] upd_idx = '0;
    logic [7:0] upd_data = '0;
    logic       uip_set = 1'b0, uip_clr = 1'b0;
    logic [2:0] flag_set = '0;
    logic [3:0] rate_sel;
    logic [2:0] div_sel;
    logic       pie, aie, uie, set_mode, bin_mode, h24_mode, uip, reload_req, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_data(upd_data),
        .uip_set(uip_set), .uip_clr(uip_clr), .flag_set(flag_set),
        .rate_sel(rate_sel), .div_sel(div_sel), .pie(pie), .aie(aie), .uie(uie),
        .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .uip(uip), .reload_req(reload_req), .irq(irq)
    );

    // {sel, we, data, do_check, expected}
    localparam int NV = 18;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'h20, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'h5A, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h21, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'hA5, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h20, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'h00, 1'b1, 8'h5A},  // R2
        {1'b0, 1'b0, 8'h00, 1'b1, 8'h20},  // R1
        {1'b0, 1'b1, 8'hA1, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'h00, 1'b1, 8'hA5},  // R1 wrap
        {1'b0, 1'b1, 8'h0D, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'h00, 1'b1, 8'h80},  // R3
        {1'b0, 1'b1, 8'h0A, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'h00, 1'b1, 8'h26},  // R3
        {1'b1, 1'b1, 8'hFF, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'h00, 1'b1, 8'h7F},  // R4
        {1'b1, 1'b1, 8'h26, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h0B, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'h00, 1'b1, 8'h02}   // R3
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic sel, input logic we, input logic [7:0] d);
        @(negedge clk);
        bus_stb = 1'b1; bus_sel = sel; bus_we = we; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    task automatic pulse_upd(input logic [6:0] i, input logic [7:0] d);
        @(negedge clk);
        upd_we = 1'b1; upd_idx = i; upd_data = d;
        @(posedge clk);
        @(negedge clk);
        upd_we = 1'b0;
    endtask

    task automatic pulse_uip(input logic s, input logic c);
        @(negedge clk);
        uip_set = s; uip_clr = c;
        @(posedge clk);
        @(negedge clk);
        uip_set = 1'b0; uip_clr = 1'b0;
    endtask

    task automatic pulse_flag(input logic [2:0] f);
        @(negedge clk);
        flag_set = f;
        @(posedge clk);
        @(negedge clk);
        flag_set = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state of decoded outputs
        check("R3 rate_sel", rate_sel, 6);
        check("R3 div_sel", div_sel, 2);
        check("R3 h24_mode", h24_mode, 1);
        check("R3 bin_mode", bin_mode, 0);
        check("R3 set_mode", set_mode, 0);
        check("R3 uip", uip, 0);
        check("R3 irq", irq, 0);
        check("R6 reload idle", reload_req, 0);
        check("R2 rdata reset", bus_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][18], VEC[i][17], VEC[i][16:9]);
            if (VEC[i][8]) check("R1/R2/R3/R4 vector", bus_rdata, VEC[i][7:0]);
        end

        // R8 uip set, R4 bit7 kept on write
        pulse_uip(1'b1, 1'b0);
        check("R8 uip set", uip, 1);
        acc(1'b0, 1'b1, 8'h0A);
        acc(1'b1, 1'b0, 8'h00);
        check("R8 read A", bus_rdata, 8'hA6);
        acc(1'b1, 1'b1, 8'h05);
        acc(1'b1, 1'b0, 8'h00);
        check("R4 write keeps uip", bus_rdata, 8'h85);
        check("R3 rate_sel decode", rate_sel, 5);
        check("R3 div_sel decode", div_sel, 0);
        check("R2 rdata holds", bus_rdata, 8'h85);
        acc(1'b1, 1'b1, 8'h26);

        // R5 enter hold mode
        acc(1'b0, 1'b1, 8'h0B);
        acc(1'b1, 1'b1, 8'h90);
        check("R5 set_mode", set_mode, 1);
        check("R5 uie forced 0", uie, 0);
        check("R5 uip cleared", uip, 0);
        check("R6 no reload on entry", reload_req, 0);
        acc(1'b1, 1'b0, 8'h00);
        check("R5 read B", bus_rdata, 8'h80);

        // R8 uip_set ignored in hold
        pulse_uip(1'b1, 1'b0);
        check("R8 uip ignored in hold", uip, 0);

        // R6/R7 in hold
        acc(1'b0, 1'b1, 8'h02);
        acc(1'b1, 1'b1, 8'h11);
        check("R6 no reload in hold", reload_req, 0);
        pulse_upd(7'd2, 8'h44);
        acc(1'b1, 1'b0, 8'h00);
        check("R7 update ignored in hold", bus_rdata, 8'h11);

        // R6 exit hold
        acc(1'b0, 1'b1, 8'h0B);
        acc(1'b1, 1'b1, 8'h06);
        check("R6 reload on exit", reload_req, 1);
        check("R3 bin_mode", bin_mode, 1);
        check("R3 set_mode clear", set_mode, 0);
        @(negedge clk);
        check("R6 reload one cycle", reload_req, 0);

        // R7 accepted and rejected indices
        pulse_upd(7'd2, 8'h33);
        acc(1'b0, 1'b1, 8'h02);
        acc(1'b1, 1'b0, 8'h00);
        check("R7 update accepted", bus_rdata, 8'h33);
        acc(1'b0, 1'b1, 8'h03);
        acc(1'b1, 1'b1, 8'h12);
        check("R6 reload on alarm write", reload_req, 1);
        pulse_upd(7'd3, 8'h77);
        acc(1'b1, 1'b0, 8'h00);
        check("R7 alarm index rejected", bus_rdata, 8'h12);
        pulse_upd(7'h20, 8'h99);
        acc(1'b0, 1'b1, 8'h20);
        acc(1'b1, 1'b0, 8'h00);
        check("R7 high index rejected", bus_rdata, 8'h5A);

        // R6 time write in run
        acc(1'b0, 1'b1, 8'h00);
        acc(1'b1, 1'b1, 8'h30);
        check("R6 reload on time write", reload_req, 1);
        @(negedge clk);
        check("R6 reload drops", reload_req, 0);

        // R8 clear
        pulse_uip(1'b1, 1'b0);
        pulse_uip(1'b0, 1'b1);
        check("R8 uip cleared", uip, 0);

        // R9/R10 flags and clearing read
        pulse_flag(3'b010);
        check("R9 irq on alarm flag", irq, 1);
        acc(1'b0, 1'b1, 8'h0C);
        acc(1'b1, 1'b0, 8'h00);
        check("R10 read C", bus_rdata, 8'hA0);
        check("R10 irq cleared", irq, 0);
        acc(1'b1, 1'b0, 8'h00);
        check("R10 C cleared", bus_rdata, 8'h00);
        pulse_flag(3'b101);
        acc(1'b1, 1'b0, 8'h00);
        check("R9 two flags", bus_rdata, 8'hD0);

        // R11 ignored writes
        acc(1'b1, 1'b1, 8'hFF);
        check("R11 irq after C write", irq, 0);
        acc(1'b1, 1'b0, 8'h00);
        check("R11 C write ignored", bus_rdata, 8'h00);
        acc(1'b0, 1'b1, 8'h0D);
        acc(1'b1, 1'b1, 8'h00);
        acc(1'b1, 1'b0, 8'h00);
        check("R11 D write ignored", bus_rdata, 8'h80);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule